// File: doc/BRIEF.md
# Interleaved multi-bank block fetch unit

This unit fills a cache line from a word-wide memory split into NUM_BANKS banks with low-order interleaving. A fill request names the word address of the first word of the block. The unit sends that address once. It then starts the reads in every bank that holds a word of the block, all in the same cycle. After the access time it returns the words one per cycle in ascending address order, with a valid flag, a last flag and a one-cycle done pulse.

A mode input chooses between two timings. In the interleaved timing the per-word access latency overlaps across banks. In the one-bank baseline timing each word pays its own address, access and return cycles. A cycle counter reports how long the most recent fill took, so the two timings can be compared directly.

The bank storage sits inside the unit as plain arrays. A separate write port loads it with data. Each array has one write port and one registered read port, so block RAM can be inferred. A new fill is accepted only when the unit is idle.

Top module: `ilv_fetch`

## Requirements
- R1: While rst is high and in the first cycle after it, out_valid, out_last, done and busy are 0 and lat_cycles is 0.
- R2: A write of value V to word address A places V in bank A mod NUM_BANKS at location A div NUM_BANKS. A later fill whose block covers A returns V for that word, and writes to other addresses leave it unchanged.
- R3: In interleaved mode (seq_mode = 0 at acceptance) with the defaults, the request is accepted at a rising edge where busy is 0 and req_valid is 1. Word k (k = 0..3), the word at address start+k, is on out_data with out_valid = 1 in the (8+k)-th cycle after that edge. out_valid is 0 in every other cycle of the fill.
- R4: In baseline mode (seq_mode = 1 at acceptance), word k is on out_data with out_valid = 1 only in cycle 8·(k+1) after the accepting edge.
- R5: out_last is 1 only together with the final word of the block. done is 1 in exactly that cycle and for one cycle only.
- R6: In the cycle done is high, lat_cycles shows the fill latency in cycles: 11 in interleaved mode and 32 in baseline mode. It holds that value until the next done.
- R7: busy is 1 from the cycle after the accepting edge through the cycle of the final word, and 0 in the cycle after that. A req_valid seen while busy is 1 is ignored and starts no fill.
- R8: The start address need not be a multiple of the block or bank count. Addresses increment modulo 2^ADDR_W, so a block starting at 0x3FE returns words 0x3FE, 0x3FF, 0x000 and 0x001.
- R9: seq_mode is sampled only at the accepting edge. Changing it during a fill changes neither the timing nor the reported latency of that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fill request, taken when busy is 0 |
| req_addr | input | ADDR_W | Word address of the first word of the block |
| seq_mode | input | 1 | 1 = one-bank baseline timing, 0 = interleaved timing |
| wr_en | input | 1 | Preload write strobe |
| wr_addr | input | ADDR_W | Preload word address |
| wr_data | input | DATA_W | Preload data |
| busy | output | 1 | A fill is in progress |
| out_valid | output | 1 | out_data holds a returned word |
| out_data | output | DATA_W | Returned word |
| out_last | output | 1 | Current word is the last of the block |
| done | output | 1 | One-cycle pulse with the final word |
| lat_cycles | output | CNT_W | Latency of the most recent fill in cycles |

## Verification
The assertions assume three things about the inputs. Preload writes happen only while the unit is idle, so a bank never sees a write and a fill read in the same cycle. rst is held for several cycles before the first fill. The reported latency can only be one of the two mode values. The bench follows these rules: it finishes the whole preload and every overwrite before it raises a request, and it changes inputs only on falling edges. It raises req_valid again during a fill to show that the request is ignored, and it flips seq_mode during a fill to show that the mode is not re-sampled.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_ACC  = 2'd2,
    ST_RET  = 2'd3
  } fill_st_e;
endpackage

// File: rtl/ilv_bank.sv
// One word-wide bank: single write port, registered read port (block RAM style).
module ilv_bank #(
  parameter int DATA_W = 32,
  parameter int LOC_W  = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LOC_W-1:0]  wr_loc,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [LOC_W-1:0]  rd_loc,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 2 ** LOC_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_loc] <= wr_data;
    if (rd_en) rd_data <= mem[rd_loc];
  end
endmodule

// File: rtl/ilv_ctrl.sv
// Fill sequencer: address cycle, access wait, return cycles, per group of words.
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int BLOCK_WORDS = 4,
  parameter int GRP_I       = 4,
  parameter int ACC_CYC     = 6,
  parameter int WOFF_W      = 3,
  parameter int CNT_W       = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              seq_mode,
  output logic              busy,
  output logic              issue,
  output logic [ADDR_W-1:0] grp_addr,
  output logic [WOFF_W-1:0] gsz,
  output logic              load,
  output logic              shift,
  output logic              emit_last,
  output logic              done,
  output logic [CNT_W-1:0]  lat_cycles
);
  localparam int ACC_W = $clog2(ACC_CYC + 1);

  fill_st_e          st;
  logic [ADDR_W-1:0] base;
  logic [WOFF_W-1:0] woff;
  logic [WOFF_W-1:0] ret_k;
  logic [ACC_W-1:0]  acc_cnt;
  logic [CNT_W-1:0]  cnt;
  logic              acc_done;
  logic              ret_end;
  logic [WOFF_W-1:0] emit_idx;
  logic [WOFF_W-1:0] woff_nxt;

  always_comb begin
    acc_done  = (st == ST_ACC) && (acc_cnt == ACC_W'(ACC_CYC - 1));
    ret_end   = (st == ST_RET) && (ret_k == gsz - WOFF_W'(1));
    load      = acc_done;
    shift     = (st == ST_RET) && !ret_end;
    emit_idx  = load ? woff : (woff + ret_k + WOFF_W'(1));
    emit_last = (load || shift) && (emit_idx == WOFF_W'(BLOCK_WORDS - 1));
    woff_nxt  = woff + gsz;
    issue     = (st == ST_ADDR);
    busy      = (st != ST_IDLE);
    grp_addr  = base + ADDR_W'(woff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      base       <= '0;
      woff       <= '0;
      ret_k      <= '0;
      acc_cnt    <= '0;
      gsz        <= WOFF_W'(1);
      cnt        <= '0;
      done       <= 1'b0;
      lat_cycles <= '0;
    end else begin
      done <= emit_last;
      if (emit_last) lat_cycles <= cnt + CNT_W'(1);
      if (st != ST_IDLE) cnt <= cnt + CNT_W'(1);
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            base <= req_addr;
            woff <= '0;
            gsz  <= seq_mode ? WOFF_W'(1) : WOFF_W'(GRP_I);
            cnt  <= CNT_W'(1);
            st   <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          acc_cnt <= '0;
          st      <= ST_ACC;
        end
        ST_ACC: begin
          acc_cnt <= acc_cnt + ACC_W'(1);
          if (acc_done) begin
            ret_k <= '0;
            st    <= ST_RET;
          end
        end
        ST_RET: begin
          ret_k <= ret_k + WOFF_W'(1);
          if (ret_end) begin
            woff <= woff_nxt;
            st   <= (woff_nxt == WOFF_W'(BLOCK_WORDS)) ? ST_IDLE : ST_ADDR;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ilv_return.sv
// Return path: captures one group of bank words in address order and shifts them out.
module ilv_return #(
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 4,
  parameter int GRP_I     = 4,
  parameter int BANK_BITS = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q,
  input  logic [BANK_BITS-1:0]             start_bank,
  input  logic                             load,
  input  logic                             shift,
  input  logic                             emit_last,
  output logic                             out_valid,
  output logic [DATA_W-1:0]                out_data,
  output logic                             out_last
);
  logic [DATA_W-1:0] hold_q [GRP_I+1];
  logic [DATA_W-1:0] ordered [GRP_I+1];

  always_comb begin
    for (int j = 0; j <= GRP_I; j++) begin
      ordered[j] = bank_q[start_bank + BANK_BITS'(j + 1)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
      for (int j = 0; j <= GRP_I; j++) hold_q[j] <= '0;
    end else begin
      out_valid <= load || shift;
      out_last  <= emit_last;
      if (load) begin
        out_data <= bank_q[start_bank];
        for (int j = 0; j <= GRP_I; j++) hold_q[j] <= ordered[j];
      end else if (shift) begin
        out_data <= hold_q[0];
        for (int j = 0; j < GRP_I; j++) hold_q[j] <= hold_q[j+1];
      end
    end
  end
endmodule

// File: rtl/ilv_fetch.sv
// Interleaved multi-bank block fetch unit (top).
module ilv_fetch
  import ilv_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 10,
  parameter int NUM_BANKS   = 4,
  parameter int BLOCK_WORDS = 4,
  parameter int ACC_CYC     = 6,
  localparam int CNT_W      = $clog2(BLOCK_WORDS * (ACC_CYC + 2) + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              seq_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              done,
  output logic [CNT_W-1:0]  lat_cycles
);
  localparam int BANK_BITS = $clog2(NUM_BANKS);
  localparam int LOC_W     = ADDR_W - BANK_BITS;
  localparam int GRP_I     = (NUM_BANKS < BLOCK_WORDS) ? NUM_BANKS : BLOCK_WORDS;
  localparam int WOFF_W    = $clog2(BLOCK_WORDS + 1);

  logic                             issue;
  logic                             load;
  logic                             shift;
  logic                             emit_last;
  logic [ADDR_W-1:0]                grp_addr;
  logic [WOFF_W-1:0]                gsz;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q;

  ilv_ctrl #(
    .ADDR_W(ADDR_W), .BLOCK_WORDS(BLOCK_WORDS), .GRP_I(GRP_I),
    .ACC_CYC(ACC_CYC), .WOFF_W(WOFF_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .seq_mode(seq_mode), .busy(busy), .issue(issue), .grp_addr(grp_addr),
    .gsz(gsz), .load(load), .shift(shift), .emit_last(emit_last),
    .done(done), .lat_cycles(lat_cycles)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_BITS-1:0] pos;
    logic [ADDR_W-1:0]    lane_addr;
    logic                 rd_en;
    logic                 wr_sel;

    always_comb begin
      pos       = BANK_BITS'(b) - grp_addr[BANK_BITS-1:0];
      lane_addr = grp_addr + ADDR_W'(pos);
      rd_en     = issue && (int'(pos) < int'(gsz));
      wr_sel    = wr_en && (wr_addr[BANK_BITS-1:0] == BANK_BITS'(b));
    end

    ilv_bank #(.DATA_W(DATA_W), .LOC_W(LOC_W)) u_bank (
      .clk(clk),
      .wr_en(wr_sel),
      .wr_loc(wr_addr[ADDR_W-1:BANK_BITS]),
      .wr_data(wr_data),
      .rd_en(rd_en),
      .rd_loc(lane_addr[ADDR_W-1:BANK_BITS]),
      .rd_data(bank_q[b])
    );
  end

  ilv_return #(
    .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .GRP_I(GRP_I), .BANK_BITS(BANK_BITS)
  ) u_ret (
    .clk(clk), .rst(rst), .bank_q(bank_q),
    .start_bank(grp_addr[BANK_BITS-1:0]),
    .load(load), .shift(shift), .emit_last(emit_last),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );
endmodule

// File: rtl/ilv_fetch_chk.sv
module ilv_fetch_chk #(
  parameter int NUM_BANKS   = 4,
  parameter int BLOCK_WORDS = 4,
  parameter int ACC_CYC     = 6
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic busy,
  input logic out_valid,
  input logic out_last,
  input logic done,
  input logic [$clog2(BLOCK_WORDS * (ACC_CYC + 2) + 2)-1:0] lat_cycles
);
  localparam int GRP_I = (NUM_BANKS < BLOCK_WORDS) ? NUM_BANKS : BLOCK_WORDS;
  localparam int LAT_I = (BLOCK_WORDS / GRP_I) * (1 + ACC_CYC + GRP_I);
  localparam int LAT_S = BLOCK_WORDS * (ACC_CYC + 2);

  assert_last_needs_valid_R5: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  assert_done_with_last_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (out_valid && out_last));

  assert_last_gives_done_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> done);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_stream_in_fill_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);

  assert_accept_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid) |=> busy);

  assert_lat_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(lat_cycles));

  assert_lat_value_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> ((int'(lat_cycles) == LAT_I) || (int'(lat_cycles) == LAT_S)));
endmodule

bind ilv_fetch ilv_fetch_chk #(
  .NUM_BANKS(NUM_BANKS), .BLOCK_WORDS(BLOCK_WORDS), .ACC_CYC(ACC_CYC)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy),
  .out_valid(out_valid), .out_last(out_last), .done(done),
  .lat_cycles(lat_cycles)
);

// File: tb/ilv_fetch_bench.sv
`timescale 1ns/1ps
module ilv_fetch_bench;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 10;
  localparam int NB     = 4;
  localparam int BW     = 4;
  localparam int ACC    = 6;
  localparam int CW     = $clog2(BW * (ACC + 2) + 2);
  localparam int GI     = (NB < BW) ? NB : BW;
  localparam int LAT_I  = (BW / GI) * (1 + ACC + GI);
  localparam int LAT_S  = BW * (ACC + 2);
  localparam int WIN    = 48;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              seq_mode = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              busy, out_valid, out_last, done;
  logic [DATA_W-1:0] out_data;
  logic [CW-1:0]     lat_cycles;

  logic [DATA_W-1:0] shadow [2**ADDR_W];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  ilv_fetch u_ilv_fetch (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .seq_mode(seq_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .done(done), .lat_cycles(lat_cycles)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 60000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic int exp_cycle(input bit mode, input int k);
    if (mode) return (k + 1) * (ACC + 2);
    return (k / GI) * (1 + ACC + GI) + ACC + 2 + (k % GI);
  endfunction

  task automatic write_word(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    shadow[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Runs one fill and reports what it saw against the bench model.
  task automatic run_fill(input logic [ADDR_W-1:0] a, input bit mode, input bit flip,
                          input bit intrude, output int nwords, output bit data_ok,
                          output bit time_ok, output bit flag_ok, output bit busy_ok,
                          output int lat_seen);
    int l;
    l = mode ? LAT_S : LAT_I;
    nwords = 0; data_ok = 1; time_ok = 1; flag_ok = 1; busy_ok = 1;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; seq_mode = mode;
    @(posedge clk);
    for (int n = 1; n <= WIN; n++) begin
      @(negedge clk);
      if (busy !== (n <= l)) busy_ok = 0;
      if (out_valid) begin
        if (nwords < BW) begin
          if (out_data !== shadow[ADDR_W'(a + ADDR_W'(nwords))]) data_ok = 0;
          if (n != exp_cycle(mode, nwords)) time_ok = 0;
        end
        if (out_last !== (nwords == BW - 1)) flag_ok = 0;
        nwords++;
      end else if (out_last) flag_ok = 0;
      if (done !== (out_valid && out_last)) flag_ok = 0;
      if (n == 1) req_valid = 1'b0;
      if (n == 3 && flip) seq_mode = ~mode;
      if (n == 5 && intrude) begin
        req_valid = 1'b1; req_addr = a + ADDR_W'(100); seq_mode = 1'b1;
      end
      if (n == 6 && intrude) begin
        req_valid = 1'b0; seq_mode = mode;
      end
    end
    lat_seen = int'(lat_cycles);
    seq_mode = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid === 0 && out_last === 0 && done === 0, "R1 outputs quiet in reset",
        {out_valid, out_last, done}, 0);
    chk(busy === 0 && lat_cycles === 0, "R1 busy and latency cleared", {busy, lat_cycles}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 0 && busy === 0 && lat_cycles === 0, "R1 first cycle after reset",
        {out_valid, busy, lat_cycles}, 0);
  endtask

  task automatic t_preload();
    for (int a = 0; a < 2**ADDR_W; a++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = ADDR_W'(a);
      wr_data = 32'hC300_0000 ^ (DATA_W'(a) * 32'h0001_0101);
      shadow[a] = 32'hC300_0000 ^ (DATA_W'(a) * 32'h0001_0101);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_aligned();
    int nw, lat; bit dok, tok, fok, bok;
    run_fill(10'h040, 1'b0, 1'b0, 1'b0, nw, dok, tok, fok, bok, lat);
    chk(nw == BW, "R3 word count aligned", nw, BW);
    chk(dok, "R2 data from banks aligned", dok, 1);
    chk(tok, "R3 interleaved word cycles", tok, 1);
    chk(fok, "R5 last and done flags", fok, 1);
    chk(bok, "R7 busy window", bok, 1);
    chk(lat == LAT_I, "R6 interleaved latency", lat, LAT_I);
  endtask

  task automatic t_unaligned();
    int nw, lat; bit dok, tok, fok, bok;
    run_fill(10'h013, 1'b0, 1'b0, 1'b0, nw, dok, tok, fok, bok, lat);
    chk(dok && nw == BW, "R8 unaligned start data", nw, BW);
    chk(tok && fok, "R8 unaligned start timing", {tok, fok}, 3);
  endtask

  task automatic t_wrap();
    int nw, lat; bit dok, tok, fok, bok;
    run_fill(10'h3FE, 1'b0, 1'b0, 1'b0, nw, dok, tok, fok, bok, lat);
    chk(dok && nw == BW, "R8 wrap past top address", {dok, nw}, {1'b1, BW});
  endtask

  task automatic t_seq();
    int nw, lat; bit dok, tok, fok, bok;
    run_fill(10'h021, 1'b1, 1'b0, 1'b0, nw, dok, tok, fok, bok, lat);
    chk(tok && nw == BW, "R4 baseline word cycles", {tok, nw}, {1'b1, BW});
    chk(dok, "R4 baseline data", dok, 1);
    chk(fok && bok, "R5 baseline flags and busy", {fok, bok}, 3);
    chk(lat == LAT_S, "R6 baseline latency", lat, LAT_S);
    repeat (10) @(negedge clk);
    chk(int'(lat_cycles) == LAT_S, "R6 latency held while idle", lat_cycles, LAT_S);
  endtask

  task automatic t_mode_flip();
    int nw, lat; bit dok, tok, fok, bok;
    run_fill(10'h0A8, 1'b0, 1'b1, 1'b0, nw, dok, tok, fok, bok, lat);
    chk(tok && nw == BW && dok, "R9 mode change mid-fill ignored", {tok, nw}, {1'b1, BW});
    chk(lat == LAT_I, "R9 latency unaffected by mode change", lat, LAT_I);
  endtask

  task automatic t_intrude();
    int nw, lat; bit dok, tok, fok, bok;
    run_fill(10'h080, 1'b0, 1'b0, 1'b1, nw, dok, tok, fok, bok, lat);
    chk(nw == BW, "R7 request while busy starts no fill", nw, BW);
    chk(dok && tok && bok, "R7 stream intact after ignored request", {dok, tok, bok}, 7);
  endtask

  task automatic t_overwrite();
    int nw, lat; bit dok, tok, fok, bok;
    write_word(10'h042, 32'hDEAD_BEEF);
    write_word(10'h046, 32'h1234_5678);
    run_fill(10'h040, 1'b0, 1'b0, 1'b0, nw, dok, tok, fok, bok, lat);
    chk(dok, "R2 overwritten word in first block", dok, 1);
    run_fill(10'h044, 1'b1, 1'b0, 1'b0, nw, dok, tok, fok, bok, lat);
    chk(dok && nw == BW, "R2 neighbour bank location separate", dok, 1);
  endtask

  initial begin
    t_reset();
    t_preload();
    t_aligned();
    t_unaligned();
    t_wrap();
    t_seq();
    t_mode_flip();
    t_intrude();
    t_overwrite();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule